// File: doc/BRIEF.md
# Inter-CPU Command Mailbox

This block is a small message exchange between a main processor and a sound processor. Each side owns two 16-bit registers that only it can write and only the other side reads. The sound processor reaches the mailbox through a 16-byte window in its I/O space. The main processor has a dedicated write port, with a select bit and byte enables, and a read port that returns one of the sound-written registers.

Whenever the main processor writes one of its registers, the block raises a level-5 interrupt request toward the sound processor. The request stays high until the sound processor writes the acknowledge location in its window. Priority masking and vectoring are left to the interrupt controller that consumes the request.

Top module: `cpu_mailbox`

## Requirements
- R1: After reset, all four registers read as zero and `irq_lvl5` is low.
- R2: A sound-side write to I/O address 0x100 loads outgoing register 0, and a write to 0x102 loads outgoing register 1, on the next clock edge. Bit 0 of the byte enables guards data bits 7:0 and bit 1 guards bits 15:8. Lanes that are not enabled keep their old contents. The result appears on `main_rdata` when `main_rd_sel` selects that register (0 or 1).
- R3: A sound-side read at 0x104 returns incoming register 0 and a read at 0x106 returns incoming register 1, in the same cycle, on `snd_rdata`.
- R4: A main-side write loads the incoming register chosen by `main_sel` (0 or 1), with the same byte-lane rule as R2. It also sets `irq_lvl5`, which is high from the following cycle.
- R5: A sound-side write to 0x10A clears `irq_lvl5` from the following cycle, regardless of the data and byte enables.
- R6: If a main-side write and a sound-side acknowledge fall in the same cycle, `irq_lvl5` is high afterwards.
- R7: `snd_rdata` is zero for reads at window offsets other than 0x4 and 0x6, for reads outside the window at 0x100–0x10F, and whenever `snd_rd` is low.
- R8: Sound-side writes to window offsets other than 0x0, 0x2 and 0xA, and sound-side writes outside the window, change no register and leave `irq_lvl5` unchanged.
- R9: With no setting write and no acknowledge, `irq_lvl5` keeps its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| snd_addr | input | 16 | Sound-side I/O byte address |
| snd_wr | input | 1 | Sound-side write strobe |
| snd_rd | input | 1 | Sound-side read strobe |
| snd_be | input | 2 | Sound-side byte enables |
| snd_wdata | input | 16 | Sound-side write data |
| snd_rdata | output | 16 | Sound-side read data (combinational) |
| main_wr | input | 1 | Main-side write strobe |
| main_sel | input | 1 | Main-side target incoming register |
| main_be | input | 2 | Main-side byte enables |
| main_wdata | input | 16 | Main-side write data |
| main_rd_sel | input | 1 | Outgoing register shown on main_rdata |
| main_rdata | output | 16 | Selected outgoing register |
| irq_lvl5 | output | 1 | Level-5 interrupt request to the sound CPU |

## Verification
The exchange is exercised with full-word writes, single-lane writes on each lane, and writes with no lane enabled. These patterns separate correct lane steering from swapped or ignored enables. Reads are swept across every window offset, a few addresses outside the window, and with the read strobe low, which exposes decode aliasing and a leaking read mux. The interrupt request is driven through set, hold, acknowledge with varied data, a simultaneous set and acknowledge, and acknowledge look-alike addresses outside the window. Together these show whether set priority and the full address compare are right.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // Byte offsets inside the sound-side window; the sound program depends on them.
    localparam logic [7:0] OFS_OUT0 = 8'h00;
    localparam logic [7:0] OFS_OUT1 = 8'h02;
    localparam logic [7:0] OFS_IN0  = 8'h04;
    localparam logic [7:0] OFS_IN1  = 8'h06;
    localparam logic [7:0] OFS_ACK  = 8'h0A;

    // Decoded sound-side access kind.
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_WR_OUT0,
        ACC_WR_OUT1,
        ACC_RD_IN0,
        ACC_RD_IN1,
        ACC_ACK
    } mbox_acc_e;

endpackage

// File: rtl/mbox_win_decode.sv
module mbox_win_decode
    import mbox_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]    WIN_BASE  = 16'h0100,
    parameter int unsigned          WIN_BYTES = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output mbox_acc_e         acc
);

    localparam int unsigned OFS_W = $clog2(WIN_BYTES);

    logic       win_hit;
    logic [7:0] ofs_ext;

    always_comb begin
        win_hit = (addr[ADDR_W-1:OFS_W] == WIN_BASE[ADDR_W-1:OFS_W]);
        ofs_ext = {{(8-OFS_W){1'b0}}, addr[OFS_W-1:0]};
    end

    always_comb begin
        acc = ACC_NONE;
        if (win_hit && wr) begin
            unique case (ofs_ext)
                OFS_OUT0: acc = ACC_WR_OUT0;
                OFS_OUT1: acc = ACC_WR_OUT1;
                OFS_ACK:  acc = ACC_ACK;
                default:  acc = ACC_NONE;
            endcase
        end else if (win_hit && rd) begin
            unique case (ofs_ext)
                OFS_IN0: acc = ACC_RD_IN0;
                OFS_IN1: acc = ACC_RD_IN1;
                default: acc = ACC_NONE;
            endcase
        end
    end

endmodule

// File: rtl/mbox_latch_bank.sv
module mbox_latch_bank #(
    parameter int unsigned NUM    = 2,
    parameter int unsigned DATA_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM-1:0]               we,
    input  logic [DATA_W/8-1:0]          be,
    input  logic [DATA_W-1:0]            wdata,
    output logic [NUM-1:0][DATA_W-1:0]   q
);

    localparam int unsigned LANES = DATA_W / 8;

    typedef struct packed {
        logic [NUM-1:0][DATA_W-1:0] lat;
    } bank_st_t;

    bank_st_t st_d;
    bank_st_t st_q;

    logic [NUM-1:0][DATA_W-1:0] merged_d;

    // Per-register lane merge: enabled lanes take new data, others hold.
    for (genvar i = 0; i < NUM; i++) begin : g_reg
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            assign merged_d[i][b*8 +: 8] = be[b] ? wdata[b*8 +: 8]
                                                 : st_q.lat[i][b*8 +: 8];
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM; i++) begin
            if (we[i]) begin
                st_d.lat[i] = merged_d[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.lat;

endmodule

// File: rtl/mbox_irq_ctl.sv
module mbox_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic irq
);

    typedef struct packed {
        logic pend;
    } irq_st_t;

    irq_st_t st_d;
    irq_st_t st_q;

    // Set has priority over clear.
    always_comb begin
        st_d = st_q;
        if (set_req) begin
            st_d.pend = 1'b1;
        end else if (clr_req) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.pend;

endmodule

// File: rtl/cpu_mailbox.sv
module cpu_mailbox
    import mbox_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 16,
    parameter int unsigned       DATA_W    = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h0100,
    parameter int unsigned       WIN_BYTES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     snd_addr,
    input  logic                  snd_wr,
    input  logic                  snd_rd,
    input  logic [DATA_W/8-1:0]   snd_be,
    input  logic [DATA_W-1:0]     snd_wdata,
    output logic [DATA_W-1:0]     snd_rdata,
    input  logic                  main_wr,
    input  logic                  main_sel,
    input  logic [DATA_W/8-1:0]   main_be,
    input  logic [DATA_W-1:0]     main_wdata,
    input  logic                  main_rd_sel,
    output logic [DATA_W-1:0]     main_rdata,
    output logic                  irq_lvl5
);

    localparam int unsigned NUM_REG = 2;

    mbox_acc_e                      acc;
    logic [NUM_REG-1:0]             out_we;
    logic [NUM_REG-1:0]             in_we;
    logic [NUM_REG-1:0][DATA_W-1:0] out_q;
    logic [NUM_REG-1:0][DATA_W-1:0] in_q;
    logic                           ack_hit;

    mbox_win_decode #(
        .ADDR_W    (ADDR_W),
        .WIN_BASE  (WIN_BASE),
        .WIN_BYTES (WIN_BYTES)
    ) u_decode (
        .addr (snd_addr),
        .wr   (snd_wr),
        .rd   (snd_rd),
        .acc  (acc)
    );

    always_comb begin
        out_we  = {acc == ACC_WR_OUT1, acc == ACC_WR_OUT0};
        in_we   = main_wr ? (main_sel ? 2'b10 : 2'b01) : 2'b00;
        ack_hit = (acc == ACC_ACK);
    end

    // Sound CPU -> main CPU registers.
    mbox_latch_bank #(
        .NUM    (NUM_REG),
        .DATA_W (DATA_W)
    ) u_out_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (out_we),
        .be    (snd_be),
        .wdata (snd_wdata),
        .q     (out_q)
    );

    // Main CPU -> sound CPU registers.
    mbox_latch_bank #(
        .NUM    (NUM_REG),
        .DATA_W (DATA_W)
    ) u_in_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (in_we),
        .be    (main_be),
        .wdata (main_wdata),
        .q     (in_q)
    );

    mbox_irq_ctl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (main_wr),
        .clr_req (ack_hit),
        .irq     (irq_lvl5)
    );

    always_comb begin
        unique case (acc)
            ACC_RD_IN0: snd_rdata = in_q[0];
            ACC_RD_IN1: snd_rdata = in_q[1];
            default:    snd_rdata = '0;
        endcase
    end

    assign main_rdata = out_q[main_rd_sel];

endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
    parameter int unsigned       ADDR_W   = 16,
    parameter int unsigned       DATA_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0100
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] snd_addr,
    input logic              snd_wr,
    input logic              snd_rd,
    input logic [DATA_W-1:0] snd_rdata,
    input logic              main_wr,
    input logic              main_rd_sel,
    input logic [DATA_W-1:0] main_rdata,
    input logic              irq_lvl5
);

    logic ack_wr;
    assign ack_wr = snd_wr && (snd_addr == WIN_BASE + ADDR_W'(10));

    // R1: request low while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_irq_low: assert (irq_lvl5 == 1'b0);
        end
    end

    // R4, R6: any main write leaves the request high
    a_r4_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        main_wr |=> irq_lvl5);

    // R5: acknowledge without concurrent set clears the request
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !main_wr) |=> !irq_lvl5);

    // R9: request holds high without acknowledge
    a_r9_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl5 && !ack_wr) |=> irq_lvl5);

    // R9: request holds low without a main write
    a_r9_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_lvl5 && !main_wr) |=> !irq_lvl5);

    // R7: no read strobe, no read data
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !snd_rd |-> (snd_rdata == '0));

    // R8: outgoing view changes only after a sound-side write
    a_r8_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !snd_wr ##1 $stable(main_rd_sel) |-> $stable(main_rdata));

endmodule

bind cpu_mailbox mbox_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .WIN_BASE (WIN_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .snd_addr    (snd_addr),
    .snd_wr      (snd_wr),
    .snd_rd      (snd_rd),
    .snd_rdata   (snd_rdata),
    .main_wr     (main_wr),
    .main_rd_sel (main_rd_sel),
    .main_rdata  (main_rdata),
    .irq_lvl5    (irq_lvl5)
);

// File: tb/cpu_mailbox_bench.sv
module cpu_mailbox_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] snd_addr = '0;
    logic        snd_wr = 1'b0;
    logic        snd_rd = 1'b0;
    logic [1:0]  snd_be = '0;
    logic [15:0] snd_wdata = '0;
    logic [15:0] snd_rdata;
    logic        main_wr = 1'b0;
    logic        main_sel = 1'b0;
    logic [1:0]  main_be = '0;
    logic [15:0] main_wdata = '0;
    logic        main_rd_sel = 1'b0;
    logic [15:0] main_rdata;
    logic        irq_lvl5;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cpu_mailbox u_cpu_mailbox (
        .clk         (clk),
        .rst_n       (rst_n),
        .snd_addr    (snd_addr),
        .snd_wr      (snd_wr),
        .snd_rd      (snd_rd),
        .snd_be      (snd_be),
        .snd_wdata   (snd_wdata),
        .snd_rdata   (snd_rdata),
        .main_wr     (main_wr),
        .main_sel    (main_sel),
        .main_be     (main_be),
        .main_wdata  (main_wdata),
        .main_rd_sel (main_rd_sel),
        .main_rdata  (main_rdata),
        .irq_lvl5    (irq_lvl5)
    );

    // Scoreboard: src 0 = snd_rdata, 1 = main_rdata, 2 = irq_lvl5
    typedef struct {
        string       tag;
        int          src;
        logic [15:0] exp;
    } item_t;

    item_t sb_q[$];
    event  ev_chk;

    initial begin
        forever begin
            @(ev_chk);
            while (sb_q.size() > 0) begin
                item_t       it;
                logic [15:0] act;
                it = sb_q.pop_front();
                case (it.src)
                    0:       act = snd_rdata;
                    1:       act = main_rdata;
                    default: act = {15'd0, irq_lvl5};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: src %0d actual %h expected %h", it.tag, it.src, act, it.exp);
                end
            end
        end
    end

    task automatic push_exp(input string tag, input int src, input logic [15:0] exp);
        #1;
        sb_q.push_back('{tag, src, exp});
        ->ev_chk;
        #1;
    endtask

    task automatic snd_write(input logic [15:0] addr, input logic [15:0] data, input logic [1:0] be);
        @(negedge clk);
        snd_addr = addr; snd_wdata = data; snd_be = be; snd_wr = 1'b1;
        @(negedge clk);
        snd_wr = 1'b0;
    endtask

    task automatic main_write(input logic sel, input logic [15:0] data, input logic [1:0] be);
        @(negedge clk);
        main_sel = sel; main_wdata = data; main_be = be; main_wr = 1'b1;
        @(negedge clk);
        main_wr = 1'b0;
    endtask

    task automatic both_write(input logic sel, input logic [15:0] data);
        @(negedge clk);
        main_sel = sel; main_wdata = data; main_be = 2'b11; main_wr = 1'b1;
        snd_addr = 16'h010A; snd_wdata = 16'h1234; snd_be = 2'b11; snd_wr = 1'b1;
        @(negedge clk);
        main_wr = 1'b0; snd_wr = 1'b0;
    endtask

    task automatic chk_snd(input string tag, input logic [15:0] addr, input logic rd, input logic [15:0] exp);
        @(negedge clk);
        snd_addr = addr; snd_rd = rd;
        push_exp(tag, 0, exp);
        snd_rd = 1'b0;
    endtask

    task automatic chk_main(input string tag, input logic sel, input logic [15:0] exp);
        @(negedge clk);
        main_rd_sel = sel;
        push_exp(tag, 1, exp);
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        @(negedge clk);
        push_exp(tag, 2, {15'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk_irq("R1", 1'b0);
        chk_main("R1", 1'b0, 16'h0000);
        chk_main("R1", 1'b1, 16'h0000);
        chk_snd("R1", 16'h0104, 1'b1, 16'h0000);
        chk_snd("R1", 16'h0106, 1'b1, 16'h0000);

        // R2: outgoing registers with byte lanes
        snd_write(16'h0100, 16'hA1B2, 2'b11);
        chk_main("R2", 1'b0, 16'hA1B2);
        snd_write(16'h0102, 16'h1234, 2'b11);
        chk_main("R2", 1'b1, 16'h1234);
        chk_main("R2", 1'b0, 16'hA1B2);
        snd_write(16'h0100, 16'hFFFF, 2'b01);
        chk_main("R2", 1'b0, 16'hA1FF);
        snd_write(16'h0100, 16'h5500, 2'b10);
        chk_main("R2", 1'b0, 16'h55FF);
        snd_write(16'h0100, 16'h9999, 2'b00);
        chk_main("R2", 1'b0, 16'h55FF);

        // R4, R3: main writes incoming registers and raises request
        main_write(1'b0, 16'hCAFE, 2'b11);
        chk_irq("R4", 1'b1);
        chk_snd("R3", 16'h0104, 1'b1, 16'hCAFE);
        main_write(1'b1, 16'hBEEF, 2'b10);
        chk_snd("R4", 16'h0106, 1'b1, 16'hBE00);
        main_write(1'b1, 16'h00EF, 2'b01);
        chk_snd("R3", 16'h0106, 1'b1, 16'hBEEF);
        chk_snd("R3", 16'h0104, 1'b1, 16'hCAFE);

        // R9: request holds with no traffic
        repeat (4) @(negedge clk);
        chk_irq("R9", 1'b1);

        // R5: acknowledge clears, data irrelevant
        snd_write(16'h010A, 16'h0000, 2'b11);
        chk_irq("R5", 1'b0);
        repeat (3) @(negedge clk);
        chk_irq("R9", 1'b0);
        main_write(1'b0, 16'hCAFE, 2'b11);
        snd_write(16'h010A, 16'hFFFF, 2'b00);
        chk_irq("R5", 1'b0);

        // R6: set and acknowledge in the same cycle
        both_write(1'b1, 16'h7777);
        chk_irq("R6", 1'b1);
        chk_snd("R6", 16'h0106, 1'b1, 16'h7777);

        // R7: reads returning zero
        chk_snd("R7", 16'h0100, 1'b1, 16'h0000);
        chk_snd("R7", 16'h0102, 1'b1, 16'h0000);
        chk_snd("R7", 16'h0108, 1'b1, 16'h0000);
        chk_snd("R7", 16'h010A, 1'b1, 16'h0000);
        chk_snd("R7", 16'h010E, 1'b1, 16'h0000);
        chk_snd("R7", 16'h0114, 1'b1, 16'h0000);
        chk_snd("R7", 16'h0004, 1'b1, 16'h0000);
        chk_snd("R7", 16'h0104, 1'b0, 16'h0000);

        // R8: writes outside the active offsets are ignored (irq is high)
        snd_write(16'h0104, 16'h1111, 2'b11);
        snd_write(16'h0106, 16'h2222, 2'b11);
        snd_write(16'h0108, 16'h3333, 2'b11);
        snd_write(16'h010C, 16'h4444, 2'b11);
        snd_write(16'h0110, 16'h5555, 2'b11);
        snd_write(16'h0002, 16'h6666, 2'b11);
        snd_write(16'h011A, 16'h0000, 2'b11);
        snd_write(16'h000A, 16'h0000, 2'b11);
        chk_irq("R8", 1'b1);
        chk_main("R8", 1'b0, 16'h55FF);
        chk_main("R8", 1'b1, 16'h1234);
        chk_snd("R8", 16'h0104, 1'b1, 16'hCAFE);
        chk_snd("R8", 16'h0106, 1'b1, 16'h7777);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule